// File: doc/BRIEF.md
# Sprite Table Copy Engine

This block fills the 160-byte sprite attribute table from a 256-byte-aligned page anywhere in the 16-bit address space. A single start strobe carries the page number. After a short startup delay the engine reads one byte per fixed step through its own bus-master read port and writes it into sprite memory through a dedicated write port. Destination indices run from 0 to 159.

While a copy is in progress, the engine also sits between the CPU and the system bus as a filter. CPU accesses to sprite memory are cut off. So are CPU accesses to an address window that conflicts with the page being copied. That window comes from source address bits [15:13], looked up in one of two tables chosen by a model-select input. A blocked read returns 0xFF and a blocked write never reaches the bus. Every other access passes through unchanged, in the same cycle.

Top module: `spr_xfer_engine`

## Requirements
- R1: A start strobe whose page value exceeds 0xF1 (source above 0xF100) is ignored: busy stays as it was and no sprite write results from it.
- R2: An accepted start copies exactly 160 bytes. Byte k is read from source address page*256+k and written to sprite index k, for k = 0..159.
- R3: The first sprite write strobe is sampled by the clock edge 8 cycles after the edge that accepted the start. Each further write comes 4 cycles after the previous one.
- R4: The data written to sprite memory is the byte returned on the source read port in the same cycle as the read strobe.
- R5: While busy, a CPU access to sprite memory (0xFE00–0xFE9F) is blocked: a read returns 0xFF and a write is not forwarded to the bus.
- R6: With model select low (older table), busy blocks CPU accesses to 0x8000–0x9FFF when the source is in 0x8000–0x9FFF, and otherwise to 0xA000–0xFDFF.
- R7: With model select high (newer table), busy blocks CPU accesses to 0x8000–0x9FFF for sources in 0x8000–0x9FFF, to 0xC000–0xFDFF for sources in 0xC000–0xDFFF, and otherwise to 0xA000–0xBFFF.
- R8: A CPU access outside every blocked range, or any access while idle, passes through unchanged: address, strobes and write data go to the bus, and bus read data comes back.
- R9: Busy rises on the edge that accepts a start and falls on the edge that takes the 160th write. A start accepted while busy restarts the copy from index 0 with a fresh 8-cycle delay.
- R10: After synchronous reset, busy, the source read strobe and the sprite write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start strobe |
| start_page_i | input | 8 | Source page (high byte of source address) |
| model_new_i | input | 1 | Conflict table select: 0 older, 1 newer |
| busy_o | output | 1 | Copy in progress |
| src_rd_o | output | 1 | Source read strobe |
| src_addr_o | output | 16 | Source read address |
| src_data_i | input | 8 | Source read data, valid in the strobe cycle |
| spr_wr_o | output | 1 | Sprite memory write strobe |
| spr_idx_o | output | 8 | Sprite memory write index |
| spr_data_o | output | 8 | Sprite memory write data |
| cpu_addr_i | input | 16 | CPU address |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Read data returned to the CPU |
| bus_addr_o | output | 16 | Address forwarded to the bus |
| bus_rd_o | output | 1 | Read strobe forwarded to the bus |
| bus_wr_o | output | 1 | Write strobe forwarded to the bus |
| bus_wdata_o | output | 8 | Write data forwarded to the bus |
| bus_rdata_i | input | 8 | Read data from the bus |

## Verification
A bad pacing timer or remaining count first shows as a sprite write strobe in the wrong cycle. That is visible at the ports no later than the first write, 8 cycles after the start. A wrong final count shows at busy's falling edge, after about 640 cycles. A corrupt source or index register shows on the first write as a mismatch between index, source address and data. A wrong conflict decode shows at once on the combinational CPU filter, so probes in several source regions under both tables catch it in the same cycle.

// File: rtl/spr_xfer_pkg.sv
package spr_xfer_pkg;

    localparam logic [15:0] SPR_LO   = 16'hFE00;
    localparam logic [15:0] SPR_HI   = 16'hFEA0;
    localparam logic [7:0]  OPEN_BUS = 8'hFF;

    typedef struct packed {
        logic [16:0] lo;   // inclusive
        logic [16:0] hi;   // exclusive
    } addr_win_t;

    typedef enum logic {
        TBL_OLD = 1'b0,
        TBL_NEW = 1'b1
    } tbl_sel_e;

    function automatic addr_win_t mk_win(input logic [16:0] lo, input logic [16:0] hi);
        addr_win_t w;
        w.lo = lo;
        w.hi = hi;
        return w;
    endfunction

    // Conflict window for a source 8 KiB region under a given table.
    function automatic addr_win_t conflict_win(input tbl_sel_e tbl, input logic [2:0] region);
        addr_win_t w;
        if (region == 3'd4) begin
            w = mk_win(17'h08000, 17'h0A000);
        end else if (tbl == TBL_OLD) begin
            w = mk_win(17'h0A000, 17'h0FE00);
        end else if (region == 3'd6) begin
            w = mk_win(17'h0C000, 17'h0FE00);
        end else begin
            w = mk_win(17'h0A000, 17'h0C000);
        end
        return w;
    endfunction

endpackage

// File: rtl/spr_xfer_pacer.sv
module spr_xfer_pacer
    import spr_xfer_pkg::*;
#(
    parameter int START_DELAY = 8,
    parameter int STEP_GAP    = 4,
    parameter int XFER_LEN    = 160,
    parameter logic [7:0] MAX_PAGE = 8'hF1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  page,
    output logic        busy,
    output logic        step,
    output logic [7:0]  idx,
    output logic [15:0] src
);
    localparam int TMAX = (START_DELAY > STEP_GAP) ? START_DELAY : STEP_GAP;
    localparam int TW   = $clog2(TMAX);
    localparam int CW   = $clog2(XFER_LEN + 1);

    typedef struct packed {
        logic          busy;
        logic [TW-1:0] tmr;
        logic [CW-1:0] left;
        logic [7:0]    idx;
        logic [15:0]   src;
    } pacer_st_t;

    pacer_st_t st;
    logic      accept;

    assign accept = start && (page <= MAX_PAGE);
    assign step   = st.busy && (st.tmr == '0);
    assign busy   = st.busy;
    assign idx    = st.idx;
    assign src    = st.src;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (accept) begin
            st.busy <= 1'b1;
            st.tmr  <= TW'(START_DELAY - 1);
            st.left <= CW'(XFER_LEN);
            st.idx  <= '0;
            st.src  <= {page, 8'h00};
        end else if (st.busy) begin
            if (st.tmr == '0) begin
                st.tmr  <= TW'(STEP_GAP - 1);
                st.idx  <= st.idx + 8'd1;
                st.src  <= st.src + 16'd1;
                st.left <= st.left - CW'(1);
                if (st.left == CW'(1)) begin
                    st.busy <= 1'b0;
                end
            end else begin
                st.tmr <= st.tmr - TW'(1);
            end
        end
    end

    // R1: an out-of-range page never starts an idle engine
    a_r1_ignore_high_page: assert property (@(posedge clk) disable iff (rst)
        (start && page > MAX_PAGE && !st.busy) |=> !st.busy);

    // R9: busy only rises on a start strobe
    a_r9_rise_on_start: assert property (@(posedge clk) disable iff (rst)
        $rose(st.busy) |-> $past(start));

    // R3: no step in the cycle right after acceptance, and steps never back to back
    a_r3_no_early_step: assert property (@(posedge clk) disable iff (rst)
        accept |=> !step);
    a_r3_step_gap: assert property (@(posedge clk) disable iff (rst)
        (step && !accept) |=> !step);

    // R2: index never leaves the table
    a_r2_idx_range: assert property (@(posedge clk) disable iff (rst)
        step |-> (st.idx < 8'(XFER_LEN)));

endmodule

// File: rtl/spr_conflict_map.sv
module spr_conflict_map
    import spr_xfer_pkg::*;
(
    input  logic       model_new,
    input  logic [2:0] region,
    output addr_win_t  win
);
    always_comb begin
        win = conflict_win(model_new ? TBL_NEW : TBL_OLD, region);
    end
endmodule

// File: rtl/spr_cpu_gate.sv
module spr_cpu_gate
    import spr_xfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  addr_win_t   win,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata
);
    logic [16:0] a17;
    logic        in_win;
    logic        in_spr;
    logic        block;

    assign a17    = {1'b0, cpu_addr};
    assign in_win = (a17 >= win.lo) && (a17 < win.hi);
    assign in_spr = (cpu_addr >= SPR_LO) && (cpu_addr < SPR_HI);
    assign block  = busy && (in_win || in_spr);

    always_comb begin
        bus_addr  = cpu_addr;
        bus_wdata = cpu_wdata;
        bus_rd    = cpu_rd && !block;
        bus_wr    = cpu_wr && !block;
        cpu_rdata = block ? OPEN_BUS : bus_rdata;
    end

    // R5: sprite memory is unreachable while busy
    a_r5_spr_sealed: assert property (@(posedge clk) disable iff (rst)
        (busy && cpu_addr >= SPR_LO && cpu_addr < SPR_HI) |-> (!bus_rd && !bus_wr));
    a_r5_spr_reads_ff: assert property (@(posedge clk) disable iff (rst)
        (busy && cpu_rd && cpu_addr >= SPR_LO && cpu_addr < SPR_HI) |-> (cpu_rdata == 8'hFF));

    // R8: idle means transparent
    a_r8_idle_pass: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_rd == cpu_rd && bus_wr == cpu_wr && cpu_rdata == bus_rdata));

endmodule

// File: rtl/spr_xfer_engine.sv
module spr_xfer_engine
    import spr_xfer_pkg::*;
#(
    parameter int START_DELAY = 8,
    parameter int STEP_GAP    = 4,
    parameter int XFER_LEN    = 160,
    parameter logic [7:0] MAX_PAGE = 8'hF1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [7:0]  start_page_i,
    input  logic        model_new_i,
    output logic        busy_o,
    output logic        src_rd_o,
    output logic [15:0] src_addr_o,
    input  logic [7:0]  src_data_i,
    output logic        spr_wr_o,
    output logic [7:0]  spr_idx_o,
    output logic [7:0]  spr_data_o,
    input  logic [15:0] cpu_addr_i,
    input  logic        cpu_rd_i,
    input  logic        cpu_wr_i,
    input  logic [7:0]  cpu_wdata_i,
    output logic [7:0]  cpu_rdata_o,
    output logic [15:0] bus_addr_o,
    output logic        bus_rd_o,
    output logic        bus_wr_o,
    output logic [7:0]  bus_wdata_o,
    input  logic [7:0]  bus_rdata_i
);
    logic        busy;
    logic        step;
    logic [7:0]  idx;
    logic [15:0] src;
    addr_win_t   win;

    spr_xfer_pacer #(
        .START_DELAY(START_DELAY),
        .STEP_GAP   (STEP_GAP),
        .XFER_LEN   (XFER_LEN),
        .MAX_PAGE   (MAX_PAGE)
    ) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .start(start_i),
        .page (start_page_i),
        .busy (busy),
        .step (step),
        .idx  (idx),
        .src  (src)
    );

    spr_conflict_map u_map (
        .model_new(model_new_i),
        .region   (src[15:13]),
        .win      (win)
    );

    spr_cpu_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .win      (win),
        .cpu_addr (cpu_addr_i),
        .cpu_rd   (cpu_rd_i),
        .cpu_wr   (cpu_wr_i),
        .cpu_wdata(cpu_wdata_i),
        .cpu_rdata(cpu_rdata_o),
        .bus_addr (bus_addr_o),
        .bus_rd   (bus_rd_o),
        .bus_wr   (bus_wr_o),
        .bus_wdata(bus_wdata_o),
        .bus_rdata(bus_rdata_i)
    );

    assign busy_o     = busy;
    assign src_rd_o   = step;
    assign src_addr_o = src;
    assign spr_wr_o   = step;
    assign spr_idx_o  = idx;
    assign spr_data_o = src_data_i;

    // R2: index and source low byte stay in lockstep
    a_r2_idx_tracks_src: assert property (@(posedge clk) disable iff (rst)
        spr_wr_o |-> (spr_idx_o == src_addr_o[7:0]));

    // R4: write data is the byte being read
    a_r4_data_forward: assert property (@(posedge clk) disable iff (rst)
        spr_wr_o |-> (src_rd_o && spr_data_o == src_data_i));

    // R10: nothing moves while idle
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!spr_wr_o && !src_rd_o));

endmodule

// File: tb/spr_xfer_engine_tb.sv
module spr_xfer_engine_tb;

    typedef struct {
        int         idx;
        logic [15:0] addr;
        int         cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [7:0]  start_page_i = '0;
    logic        model_new_i = 1'b0;
    logic        busy_o;
    logic        src_rd_o;
    logic [15:0] src_addr_o;
    logic [7:0]  src_data_i;
    logic        spr_wr_o;
    logic [7:0]  spr_idx_o;
    logic [7:0]  spr_data_o;
    logic [15:0] cpu_addr_i = '0;
    logic        cpu_rd_i = 1'b0;
    logic        cpu_wr_i = 1'b0;
    logic [7:0]  cpu_wdata_i = 8'h3C;
    logic [7:0]  cpu_rdata_o;
    logic [15:0] bus_addr_o;
    logic        bus_rd_o;
    logic        bus_wr_o;
    logic [7:0]  bus_wdata_o;
    logic [7:0]  bus_rdata_i = 8'h5A;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc   = 0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h96;
    endfunction
    assign src_data_i = src_byte(src_addr_o);

    spr_xfer_engine u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // driver: issue start at a negedge, queue the expected writes
    task automatic start_xfer(input logic [7:0] page);
        q.delete();
        for (int k = 0; k < 160; k++) begin
            exp_t e;
            e.idx  = k;
            e.addr = {page, 8'(k)};
            e.cyc  = cyc + 8 + 4 * k;
            q.push_back(e);
        end
        start_page_i = page;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor: pop and compare each sprite write (R2, R3, R4)
    always @(negedge clk) begin
        if (!rst && spr_wr_o) begin
            if (q.size() == 0) begin
                check("R1/R2 unexpected write", 32'(spr_idx_o), 32'hFFFF);
            end else begin
                exp_t e;
                e = q.pop_front();
                check("R2 index", 32'(spr_idx_o), 32'(e.idx));
                check("R2 source address", 32'(src_addr_o), 32'(e.addr));
                check("R4 data", 32'(spr_data_o), 32'(src_byte(e.addr)));
                check("R3 timing", 32'(cyc), 32'(e.cyc));
            end
        end
    end

    function automatic bit exp_block(input bit mnew, input logic [7:0] page, input logic [15:0] a);
        logic [2:0] r;
        r = page[7:5];
        if (a >= 16'hFE00 && a < 16'hFEA0) return 1'b1;
        if (r == 3'd4) return (a >= 16'h8000 && a < 16'hA000);
        if (!mnew) return (a >= 16'hA000 && a < 16'hFE00);
        if (r == 3'd6) return (a >= 16'hC000 && a < 16'hFE00);
        return (a >= 16'hA000 && a < 16'hC000);
    endfunction

    task automatic probe(input string req, input logic [15:0] a, input bit wr, input bit blk);
        @(negedge clk);
        cpu_addr_i = a;
        cpu_rd_i = !wr;
        cpu_wr_i = wr;
        #1;
        check({req, " addr"}, 32'(bus_addr_o), 32'(a));
        if (wr) begin
            check({req, " write fwd"}, 32'(bus_wr_o), 32'(!blk));
            check({req, " wdata"}, 32'(bus_wdata_o), 32'(cpu_wdata_i));
        end else begin
            check({req, " read fwd"}, 32'(bus_rd_o), 32'(!blk));
            check({req, " rdata"}, 32'(cpu_rdata_o), blk ? 32'hFF : 32'h5A);
        end
        cpu_rd_i = 1'b0;
        cpu_wr_i = 1'b0;
    endtask

    task automatic window_run(input bit mnew, input logic [7:0] page, input string req);
        logic [15:0] pts[8];
        pts = '{16'h7FFF, 16'h8000, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hFDFF, 16'hFE10};
        model_new_i = mnew;
        start_xfer(page);
        foreach (pts[i]) probe(req, pts[i], 1'b0, exp_block(mnew, page, pts[i]));
        probe("R5 write", 16'hFE9F, 1'b1, 1'b1);
        probe("R8 outside", 16'hFEA0, 1'b0, 1'b0);
        while (busy_o) @(negedge clk);
        check({req, " queue drained"}, 32'(q.size()), 32'd0);
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        check("R10 busy", 32'(busy_o), 0);
        check("R10 wr", 32'(spr_wr_o), 0);
        check("R10 rd", 32'(src_rd_o), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: page 0xF2 ignored
        start_page_i = 8'hF2;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R1 busy after F2", 32'(busy_o), 0);
        repeat (20) @(negedge clk);
        check("R1 still idle", 32'(busy_o), 0);

        // R8 idle pass-through into sprite memory
        probe("R8 idle", 16'hFE10, 1'b0, 1'b0);
        probe("R8 idle write", 16'hFE10, 1'b1, 1'b0);

        // R9: busy rises on accepting edge, falls after last write; page F1 accepted
        model_new_i = 1'b0;
        start_xfer(8'hF1);
        check("R9 busy after start", 32'(busy_o), 1);
        t0 = cyc;
        while (busy_o) @(negedge clk);
        check("R9 busy length", 32'(cyc - t0), 32'(7 + 4 * 159 + 1));
        check("R2 all written", 32'(q.size()), 0);

        // R1 ignored while busy: copy continues unchanged
        start_xfer(8'h12);
        repeat (5) @(negedge clk);
        start_page_i = 8'hFF;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        check("R1 ignored while busy", 32'(q.size()), 0);

        // R9 restart mid-copy
        start_xfer(8'h30);
        repeat (30) @(negedge clk);
        start_xfer(8'h45);
        while (busy_o) @(negedge clk);
        check("R9 restart drained", 32'(q.size()), 0);

        // R6 older table, R7 newer table
        window_run(1'b0, 8'hC0, "R6 old C0");
        window_run(1'b0, 8'h80, "R6 old 80");
        window_run(1'b0, 8'h00, "R6 old 00");
        window_run(1'b1, 8'hC0, "R7 new C0");
        window_run(1'b1, 8'h80, "R7 new 80");
        window_run(1'b1, 8'hA0, "R7 new A0");
        window_run(1'b1, 8'hE5, "R7 new E5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule